// File: doc/BRIEF.md
# Two-Byte Strobed Register Write Port

This block receives register writes from an 8-bit parallel host port with a separate strobe line. It stores them in a bank of sixteen 7-bit control registers. The host sends every write as two strobed bytes. The top bit of each byte says what the byte is:

- A clear top bit marks an address byte. Its low seven bits choose the register.
- A set top bit marks a data byte. Its low seven bits are stored in the register chosen by the last address byte.

The address stays in place after a data byte, so several data bytes in a row overwrite the same register.

The strobe comes from an unclocked host. It passes through a synchronizer and then a rising-edge detector, so each pulse causes exactly one capture however long it lasts. The captured byte then goes to a small state machine with three states:

- `S_NO_ADDR`: no address has been received since reset.
- `S_ARMED`: an address is held.
- `S_COMMIT`: a single cycle in which the register write is issued.

The transitions are named as follows:

| Transition | From | To | Trigger |
|---|---|---|---|
| `T_FIRST_ADDR` | `S_NO_ADDR` | `S_ARMED` | address byte |
| `T_DROP_DATA` | `S_NO_ADDR` | `S_NO_ADDR` | data byte (discarded) |
| `T_READDR` | `S_ARMED` or `S_COMMIT` | `S_ARMED` | address byte |
| `T_LOAD_DATA` | `S_ARMED` or `S_COMMIT` | `S_COMMIT` | data byte |
| `T_DONE` | `S_COMMIT` | `S_ARMED` | no strobe |

Besides the full register bank, the block decodes a few fields as separate outputs: a 24-bit integration count, a conversion-run enable, a test-mode enable, a 3-bit range code and a 7-bit packet count.

Top module: `regport_write_port`

## Requirements
- R1: After reset all sixteen registers are zero, and so are all decoded outputs.
- R2: A byte with bit 7 = 0 latches its bits 6:0 as the write address and changes no register.
- R3: A byte with bit 7 = 1 writes its bits 6:0 into the register at the latched address. The address stays latched, so later data bytes write the same register again.
- R4: Each rising edge of the strobe causes exactly one byte capture. Holding the strobe high, or changing the byte while it stays high, causes no further capture.
- R5: A data byte that arrives before any address byte since reset is discarded and changes no register.
- R6: A data byte whose latched address is 16 or more changes no register.
- R7: The integration count output is formed from four registers:
  - bits 23:21 from register 2, bits 2:0 (the upper bits of register 2 are unused);
  - bits 20:14 from register 3;
  - bits 13:7 from register 4;
  - bits 6:0 from register 5.
- R8: Register 6 holds two fields: bit 3 drives the test-mode enable, and bits 2:0 drive the range code (0 to 7).
- R9: Bit 0 of register 7 drives the conversion-run enable; 0 holds conversion.
- R10: Register 11 drives the packet-count output.
- R11: Register i appears on reg_flat bits [7*i+6 : 7*i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| host_byte | input | 8 | Parallel host byte; bit 7 selects address or data |
| host_stb | input | 1 | Asynchronous host strobe; a rising edge captures host_byte |
| reg_flat | output | 112 | All sixteen 7-bit registers, register i at [7*i +: 7] |
| integ_count | output | 24 | Integration count assembled from registers 2 to 5 |
| run_enable | output | 1 | Conversion-run enable, register 7 bit 0 |
| test_enable | output | 1 | Test-mode enable, register 6 bit 3 |
| range_code | output | 3 | Range code, register 6 bits 2:0 |
| packet_count | output | 7 | Packet count, register 11 |

## Verification
The assertions assume three things about the host:
- host_byte is stable from before the strobe rises until after the synchronized edge has been seen;
- strobe pulses are at least a few clocks high and a few clocks low;
- consequently, no two captures fall in adjacent cycles.

The bench keeps within these limits. It sets the byte two clocks before raising the strobe, holds the strobe high for four clocks and low for six, and keeps the byte unchanged throughout. The one exception is the held-strobe case: there the byte changes only after the capture point, to show that a long pulse does not cause a second capture.

// File: rtl/regport_pkg.sv
package regport_pkg;
    localparam int BYTE_W    = 8;
    localparam int PAYLOAD_W = BYTE_W - 1;
    localparam int NUM_REGS  = 16;
    localparam int FLAT_W    = NUM_REGS * PAYLOAD_W;
    localparam int CNT_W     = 24;

    localparam int ADDR_CNT_HI  = 2;
    localparam int ADDR_CNT_MH  = 3;
    localparam int ADDR_CNT_ML  = 4;
    localparam int ADDR_CNT_LO  = 5;
    localparam int ADDR_CTRL    = 6;
    localparam int ADDR_RUN     = 7;
    localparam int ADDR_PACKETS = 11;

    localparam int TEST_BIT  = 3;
    localparam int RANGE_W   = 3;
    localparam int RUN_BIT   = 0;

    typedef enum logic [1:0] {
        S_NO_ADDR = 2'd0,
        S_ARMED   = 2'd1,
        S_COMMIT  = 2'd2
    } port_state_t;
endpackage

// File: rtl/strobe_edge_sync.sv
module strobe_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_async,
    output logic stb_rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], stb_async};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign stb_rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/byte_decode_fsm.sv
module byte_decode_fsm
    import regport_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stb_rise,
    input  logic [BYTE_W-1:0]    byte_in,
    output logic                 wr_en,
    output logic [PAYLOAD_W-1:0] wr_addr,
    output logic [PAYLOAD_W-1:0] wr_data,
    output port_state_t          state
);
    port_state_t          state_q, state_d;
    logic [PAYLOAD_W-1:0] addr_q;
    logic [PAYLOAD_W-1:0] data_q;
    logic                 is_data;

    assign is_data = byte_in[BYTE_W-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_NO_ADDR;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_NO_ADDR: begin
                if (stb_rise && !is_data) state_d = S_ARMED;      // T_FIRST_ADDR
                else                      state_d = S_NO_ADDR;    // T_DROP_DATA
            end
            S_ARMED: begin
                if (stb_rise && is_data)  state_d = S_COMMIT;     // T_LOAD_DATA
                else                      state_d = S_ARMED;      // T_READDR
            end
            S_COMMIT: begin
                if (stb_rise && is_data)  state_d = S_COMMIT;     // T_LOAD_DATA
                else                      state_d = S_ARMED;      // T_DONE / T_READDR
            end
            default:                      state_d = S_NO_ADDR;
        endcase
    end

    // payload holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (stb_rise) begin
            if (!is_data)                    addr_q <= byte_in[PAYLOAD_W-1:0];
            else if (state_q != S_NO_ADDR)   data_q <= byte_in[PAYLOAD_W-1:0];
        end
    end

    // outputs
    always_comb begin
        wr_en   = (state_q == S_COMMIT);
        wr_addr = addr_q;
        wr_data = data_q;
        state   = state_q;
    end
endmodule

// File: rtl/reg_bank.sv
module reg_bank
    import regport_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [PAYLOAD_W-1:0] wr_addr,
    input  logic [PAYLOAD_W-1:0] wr_data,
    output logic [FLAT_W-1:0]    reg_flat
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [PAYLOAD_W-1:0] val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                val_q <= '0;
            else if (wr_en && (wr_addr == PAYLOAD_W'(i)))
                val_q <= wr_data;
        end
        assign reg_flat[i*PAYLOAD_W +: PAYLOAD_W] = val_q;
    end
endmodule

// File: rtl/field_decode.sv
module field_decode
    import regport_pkg::*;
(
    input  logic [FLAT_W-1:0]    reg_flat,
    output logic [CNT_W-1:0]     integ_count,
    output logic                 run_enable,
    output logic                 test_enable,
    output logic [RANGE_W-1:0]   range_code,
    output logic [PAYLOAD_W-1:0] packet_count
);
    localparam int TOP_W = CNT_W - 3 * PAYLOAD_W;

    logic [PAYLOAD_W-1:0] r_hi, r_mh, r_ml, r_lo, r_ctrl, r_run;

    always_comb begin
        r_hi   = reg_flat[ADDR_CNT_HI  * PAYLOAD_W +: PAYLOAD_W];
        r_mh   = reg_flat[ADDR_CNT_MH  * PAYLOAD_W +: PAYLOAD_W];
        r_ml   = reg_flat[ADDR_CNT_ML  * PAYLOAD_W +: PAYLOAD_W];
        r_lo   = reg_flat[ADDR_CNT_LO  * PAYLOAD_W +: PAYLOAD_W];
        r_ctrl = reg_flat[ADDR_CTRL    * PAYLOAD_W +: PAYLOAD_W];
        r_run  = reg_flat[ADDR_RUN     * PAYLOAD_W +: PAYLOAD_W];
        integ_count  = {r_hi[TOP_W-1:0], r_mh, r_ml, r_lo};
        run_enable   = r_run[RUN_BIT];
        test_enable  = r_ctrl[TEST_BIT];
        range_code   = r_ctrl[RANGE_W-1:0];
        packet_count = reg_flat[ADDR_PACKETS * PAYLOAD_W +: PAYLOAD_W];
    end
endmodule

// File: rtl/regport_write_port.sv
module regport_write_port
    import regport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           host_byte,
    input  logic                 host_stb,
    output logic [111:0]         reg_flat,
    output logic [23:0]          integ_count,
    output logic                 run_enable,
    output logic                 test_enable,
    output logic [2:0]           range_code,
    output logic [6:0]           packet_count
);
    logic                 stb_rise;
    logic                 wr_en;
    logic [PAYLOAD_W-1:0] wr_addr;
    logic [PAYLOAD_W-1:0] wr_data;
    port_state_t          state;

    strobe_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb_async (host_stb),
        .stb_rise  (stb_rise)
    );

    byte_decode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb_rise (stb_rise),
        .byte_in  (host_byte),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .state    (state)
    );

    reg_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .reg_flat (reg_flat)
    );

    field_decode u_fields (
        .reg_flat     (reg_flat),
        .integ_count  (integ_count),
        .run_enable   (run_enable),
        .test_enable  (test_enable),
        .range_code   (range_code),
        .packet_count (packet_count)
    );
endmodule

// File: rtl/regport_write_port_chk.sv
module regport_write_port_chk
    import regport_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 stb_rise,
    input logic [7:0]           host_byte,
    input logic                 wr_en,
    input logic [PAYLOAD_W-1:0] wr_addr,
    input logic [111:0]         reg_flat
);
    logic seen_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        seen_addr <= 1'b0;
        else if (stb_rise && !host_byte[7]) seen_addr <= 1'b1;
    end

    // R4: one capture per strobe pulse
    assert_single_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stb_rise |=> !stb_rise);

    // R4: a write is only issued after a capture
    assert_write_follows_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(stb_rise));

    // R3: registers move only through a write
    assert_hold_without_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(reg_flat));

    // R6: writes beyond the bank leave it untouched
    assert_unused_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= PAYLOAD_W'(NUM_REGS)) |=> $stable(reg_flat));

    // R5: no write before an address byte has been seen
    assert_no_write_before_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> seen_addr);
endmodule

bind regport_write_port regport_write_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb_rise  (stb_rise),
    .host_byte (host_byte),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .reg_flat  (reg_flat)
);

// File: tb/tb_regport_write_port.sv
`timescale 1ns/1ps
module tb_regport_write_port;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   host_byte = 8'h00;
    logic         host_stb = 1'b0;
    logic [111:0] reg_flat;
    logic [23:0]  integ_count;
    logic         run_enable, test_enable;
    logic [2:0]   range_code;
    logic [6:0]   packet_count;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    regport_write_port dut (
        .clk(clk), .rst_n(rst_n), .host_byte(host_byte), .host_stb(host_stb),
        .reg_flat(reg_flat), .integ_count(integ_count), .run_enable(run_enable),
        .test_enable(test_enable), .range_code(range_code), .packet_count(packet_count)
    );

    typedef struct {
        logic [111:0] snap;
        string        tag;
    } exp_t;

    exp_t       sb_q[$];
    event       byte_done;
    logic [6:0] mreg [16];
    logic [6:0] maddr;
    bit         mvalid;

    function automatic logic [111:0] model_flat();
        logic [111:0] f;
        for (int i = 0; i < 16; i++) f[i*7 +: 7] = mreg[i];
        return f;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: one strobed byte, then push the expected register image
    task automatic send_byte(input logic [7:0] b, input string tag);
        exp_t e;
        @(negedge clk) host_byte = b;
        repeat (2) @(negedge clk);
        host_stb = 1'b1;
        repeat (4) @(negedge clk);
        host_stb = 1'b0;
        repeat (6) @(negedge clk);
        if (!b[7]) begin
            maddr  = b[6:0];
            mvalid = 1'b1;
        end else if (mvalid && maddr < 7'd16) begin
            mreg[maddr] = b[6:0];
        end
        e.snap = model_flat();
        e.tag  = tag;
        sb_q.push_back(e);
        -> byte_done;
        @(negedge clk);
    endtask

    task automatic write_reg(input int a, input logic [6:0] d, input string tag);
        send_byte({1'b0, 7'(a)}, tag);
        send_byte({1'b1, d}, tag);
    endtask

    // monitor: pop and compare
    initial begin
        forever begin
            @(byte_done);
            #1;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (reg_flat !== e.snap) begin
                    errors++;
                    $display("FAIL %s reg_flat actual=%h expected=%h", e.tag, reg_flat, e.snap);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [23:0] exp_cnt;
        for (int i = 0; i < 16; i++) mreg[i] = '0;
        mvalid = 1'b0;
        maddr  = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 reg_flat", reg_flat[31:0], 32'h0);
        check("R1 reg_flat hi", {8'h0, reg_flat[111:88]}, 32'h0);
        check("R1 integ_count", integ_count, 32'h0);
        check("R1 run/test/range", {run_enable, test_enable, range_code}, 32'h0);
        check("R1 packet_count", packet_count, 32'h0);

        // R5 data before any address is dropped
        send_byte(8'hC5, "R5 early data");
        check("R5 packet_count", packet_count, 32'h0);

        // R2 address byte alone changes nothing; R3 data follows
        send_byte(8'h06, "R2 address only");
        send_byte(8'h8D, "R3 data to reg6");
        check("R8 test_enable", test_enable, 32'h1);
        check("R8 range_code", range_code, 32'h5);
        send_byte(8'h83, "R3 repeat data same addr");
        check("R8 test_enable off", test_enable, 32'h0);
        check("R8 range_code 3", range_code, 32'h3);

        // R7 integration count assembly
        write_reg(2, 7'h7D, "R7 reg2");
        write_reg(3, 7'h2B, "R7 reg3");
        write_reg(4, 7'h55, "R7 reg4");
        write_reg(5, 7'h1E, "R7 reg5");
        exp_cnt = {3'h5, 7'h2B, 7'h55, 7'h1E};
        check("R7 integ_count", integ_count, exp_cnt);

        // R9 run enable
        write_reg(7, 7'h01, "R9 run on");
        check("R9 run_enable on", run_enable, 32'h1);
        write_reg(7, 7'h7E, "R9 run held");
        check("R9 run_enable off", run_enable, 32'h0);

        // R10 packet count
        write_reg(11, 7'h2A, "R10 packets");
        check("R10 packet_count", packet_count, 32'h2A);

        // R6 unused addresses
        write_reg(16, 7'h7F, "R6 addr 16");
        write_reg(127, 7'h55, "R6 addr 127");
        check("R6 packet_count kept", packet_count, 32'h2A);

        // R11 bank edges
        write_reg(0, 7'h11, "R11 reg0");
        write_reg(15, 7'h6C, "R11 reg15");
        check("R11 reg0 slice", reg_flat[6:0], 32'h11);
        check("R11 reg15 slice", reg_flat[111:105], 32'h6C);

        // R4 long strobe: byte changed while strobe stays high
        send_byte(8'h0B, "R4 addr 11");
        @(negedge clk) host_byte = 8'h99;
        repeat (2) @(negedge clk);
        host_stb = 1'b1;
        repeat (8) @(negedge clk);
        host_byte = 8'hF7;
        repeat (20) @(negedge clk);
        host_stb = 1'b0;
        repeat (6) @(negedge clk);
        check("R4 single capture", packet_count, 32'h19);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule